// File: doc/BRIEF.md
# Retriggerable Fixed-Length Pulse Timer

This block produces a single pulse of fixed length. The timer has two control inputs that act at once, without waiting for a clock edge. A trigger input drives the output high and loads an internal down-counter. A clear input drives the output low and empties the counter. After the trigger is released, the counter steps down by one on each rising clock edge. The output falls on the edge that brings the counter to zero.

The interval length is a parameter and defaults to seven clock cycles. A trigger that arrives while a pulse is already running reloads the counter, so the full interval starts again. Once the pulse has ended, the block sits idle with the output low until the next trigger.

Top module: `pulse_timer`

## Requirements
- R1: Asserting `clear` drives `pulse` to 0 without waiting for a clock edge, and the timer stays idle while `clear` is held.
- R2: Asserting `trig` while `clear` is low drives `pulse` to 1 without waiting for a clock edge.
- R3: When `clear` and `trig` are both high, `clear` wins: `pulse` is 0.
- R4: After `trig` falls, `pulse` stays 1 across the first PULSE_CYCLES-1 rising edges and goes to 0 on rising edge number PULSE_CYCLES (the seventh edge by default). Throughout, `pulse` is 1 exactly while the internal count is nonzero.
- R5: While `trig` is held high across clock edges, the interval does not advance. Counting begins with the first rising edge after `trig` falls.
- R6: Once `pulse` is 0 and `trig` stays low, `pulse` remains 0 on every later edge.
- R7: A new `trig` while `pulse` is high restarts the full interval, measured from the new release.
- R8: With PULSE_CYCLES = 1, `pulse` falls on the first rising edge after `trig` is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the count steps down on its rising edge |
| clear | input | 1 | Asynchronous clear, active high; overrides `trig` |
| trig | input | 1 | Asynchronous start or restart of the pulse, active high |
| pulse | output | 1 | Timer output; high during the interval |

## Verification
The bench builds two copies of the block, driven by the same trigger and clear. One copy uses the default interval of seven cycles. The other uses an interval of one cycle, whose counter is a single bit. The seven-cycle copy reaches the mid-interval restart and the exact falling edge after a long count. The one-cycle copy reaches the case where the load value and the last count value are the same, so the pulse must end on the first edge after release.

// File: rtl/pt_pkg.sv
package pt_pkg;

  typedef enum logic [0:0] {
    CNT_HOLD = 1'b0,
    CNT_STEP = 1'b1
  } cnt_cmd_e;

  function automatic int count_width(input int cycles);
    return (cycles < 2) ? 1 : $clog2(cycles + 1);
  endfunction

endpackage

// File: rtl/pt_ctrl.sv
module pt_ctrl
  import pt_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             clear,
  input  logic             trig,
  input  logic [CNT_W-1:0] cnt,
  output cnt_cmd_e         cmd,
  output logic             expire
);

  function automatic logic is_last(input logic [CNT_W-1:0] c);
    return c == CNT_W'(1);
  endfunction

  logic running;
  assign running = (cnt != '0);

  always_comb begin
    cmd = (running && !trig) ? CNT_STEP : CNT_HOLD;
  end

  assign expire = (cmd == CNT_STEP) && is_last(cnt);

  // R4: an expiry event leaves the counter empty on the next edge
  p_expire_empties_r4: assert property (@(posedge clk) disable iff (clear)
    (expire && !trig) |=> (trig || clear || cnt == '0));

  // R5: the counter is never told to step while the trigger is held
  p_no_step_in_trig_r5: assert property (@(posedge clk) disable iff (clear)
    trig |-> (cmd == CNT_HOLD));

endmodule

// File: rtl/pt_counter.sv
module pt_counter
  import pt_pkg::*;
#(
  parameter int PULSE_CYCLES = 7,
  parameter int CNT_W        = 3
) (
  input  logic             clk,
  input  logic             clear,
  input  logic             trig,
  input  cnt_cmd_e         cmd,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_CYCLES);

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c,
                                                  input cnt_cmd_e k);
    return (k == CNT_STEP) ? c - CNT_W'(1) : c;
  endfunction

  always_ff @(posedge clk or posedge clear or posedge trig) begin
    if (clear)     cnt <= '0;
    else if (trig) cnt <= LOAD;
    else           cnt <= next_count(cnt, cmd);
  end

  // R1: a held clear keeps the counter empty
  p_clear_empties_r1: assert property (@(posedge clk)
    clear |-> (cnt == '0));

  // R3: with both inputs high, the counter is empty and not loaded
  p_clear_wins_r3: assert property (@(posedge clk)
    (clear && trig) |-> (cnt == '0));

  // R5: a held trigger keeps the full load value
  p_trig_loads_r5: assert property (@(posedge clk) disable iff (clear)
    trig |-> (cnt == LOAD));

  // R4: a running count drops by exactly one per edge
  p_step_down_r4: assert property (@(posedge clk) disable iff (clear)
    (cnt != '0 && !trig) |=> (trig || clear || cnt == $past(cnt) - CNT_W'(1)));

  // R6: an empty counter stays empty without a trigger
  p_idle_holds_r6: assert property (@(posedge clk) disable iff (clear)
    (cnt == '0 && !trig) |=> (trig || cnt == '0));

endmodule

// File: rtl/pt_out_reg.sv
module pt_out_reg (
  input  logic clk,
  input  logic clear,
  input  logic trig,
  input  logic expire,
  input  logic cnt_live,
  output logic pulse
);

  always_ff @(posedge clk or posedge clear or posedge trig) begin
    if (clear)       pulse <= 1'b0;
    else if (trig)   pulse <= 1'b1;
    else if (expire) pulse <= 1'b0;
  end

  // R4: the output register agrees with the counter state
  p_pulse_tracks_count_r4: assert property (@(posedge clk) disable iff (clear)
    pulse == cnt_live);

  // R2: a trigger holds the output high
  p_trig_high_r2: assert property (@(posedge clk) disable iff (clear)
    trig |-> pulse);

  // R1: a held clear holds the output low
  p_clear_low_r1: assert property (@(posedge clk)
    clear |-> !pulse);

endmodule

// File: rtl/pulse_timer.sv
module pulse_timer
  import pt_pkg::*;
#(
  parameter int PULSE_CYCLES = 7
) (
  input  logic clk,
  input  logic clear,
  input  logic trig,
  output logic pulse
);

  localparam int CNT_W = count_width(PULSE_CYCLES);

  logic [CNT_W-1:0] cnt;
  cnt_cmd_e         cmd;
  logic             expire;
  logic             cnt_live;

  assign cnt_live = (cnt != '0);

  pt_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk    (clk),
    .clear  (clear),
    .trig   (trig),
    .cnt    (cnt),
    .cmd    (cmd),
    .expire (expire)
  );

  pt_counter #(.PULSE_CYCLES(PULSE_CYCLES), .CNT_W(CNT_W)) u_counter (
    .clk   (clk),
    .clear (clear),
    .trig  (trig),
    .cmd   (cmd),
    .cnt   (cnt)
  );

  pt_out_reg u_out (
    .clk      (clk),
    .clear    (clear),
    .trig     (trig),
    .expire   (expire),
    .cnt_live (cnt_live),
    .pulse    (pulse)
  );

endmodule

// File: tb/sim_pulse_timer.sv
module sim_pulse_timer;

  logic clk = 1'b0;
  logic clear;
  logic trig;
  logic pulse;
  logic pulse1;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  pulse_timer u0 (.clk(clk), .clear(clear), .trig(trig), .pulse(pulse));
  pulse_timer #(.PULSE_CYCLES(1)) u1 (.clk(clk), .clear(clear), .trig(trig), .pulse(pulse1));

  task automatic chk(input logic act, input logic exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // fire a trigger held across one edge and release it at a falling edge
  task automatic fire();
    trig = 1'b1;
    step();
    trig = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(pulse, 1'b0, "R1 reset state");
    step();
    chk(pulse, 1'b0, "R1 held clear");
    clear = 1'b0;
    step();
    chk(pulse, 1'b0, "R6 idle after reset");
  endtask

  task automatic t_interval();
    trig = 1'b1;
    #1;
    chk(pulse, 1'b1, "R2 trig async high");
    @(negedge clk);
    trig = 1'b0;
    chk(pulse1, 1'b1, "R8 short pulse high before edge");
    for (int k = 1; k <= 7; k++) begin
      step();
      chk(pulse, (k < 7) ? 1'b1 : 1'b0, $sformatf("R4 edge %0d after release", k));
      if (k == 1) chk(pulse1, 1'b0, "R8 short pulse ends at edge 1");
    end
    for (int k = 0; k < 3; k++) begin
      step();
      chk(pulse, 1'b0, "R6 stays low");
    end
  endtask

  task automatic t_hold_trig();
    trig = 1'b1;
    for (int k = 0; k < 5; k++) step();
    chk(pulse, 1'b1, "R5 high while trig held");
    trig = 1'b0;
    for (int k = 1; k <= 7; k++) begin
      step();
      if (k == 6) chk(pulse, 1'b1, "R5 count starts after release");
      if (k == 7) chk(pulse, 1'b0, "R5 falls at seventh edge after release");
    end
  endtask

  task automatic t_retrigger();
    fire();
    for (int k = 0; k < 4; k++) step();
    chk(pulse, 1'b1, "R7 running before retrigger");
    fire();
    for (int k = 1; k <= 7; k++) begin
      step();
      if (k == 5) chk(pulse, 1'b1, "R7 restarted interval still high");
      if (k == 6) chk(pulse, 1'b1, "R7 high at sixth edge");
      if (k == 7) chk(pulse, 1'b0, "R7 falls at seventh edge");
    end
  endtask

  task automatic t_async_clear();
    fire();
    step();
    step();
    chk(pulse, 1'b1, "R1 running before clear");
    clear = 1'b1;
    #1;
    chk(pulse, 1'b0, "R1 clear async low");
    chk(pulse1, 1'b0, "R1 clear async low short");
    @(negedge clk);
    step();
    clear = 1'b0;
    for (int k = 0; k < 3; k++) begin
      step();
      chk(pulse, 1'b0, "R6 low after clear");
    end
  endtask

  task automatic t_priority();
    clear = 1'b1;
    trig  = 1'b1;
    #1;
    chk(pulse, 1'b0, "R3 clear beats trig");
    step();
    chk(pulse, 1'b0, "R3 clear beats trig across edge");
    trig = 1'b0;
    step();
    clear = 1'b0;
    step();
    chk(pulse, 1'b0, "R3 nothing started");
  endtask

  initial begin
    clear = 1'b1;
    trig  = 1'b0;
    t_reset();
    t_interval();
    t_hold_trig();
    t_retrigger();
    t_async_clear();
    t_priority();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #4000000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule